// File: doc/BRIEF.md
# Dual-Modulus Swallow Divider Control

This block is the digital half of a PLL feedback divider. It is clocked by the output pulses of an external dual-modulus prescaler, and it drives that prescaler's modulus-select line. The prescaler divides by M+1 while the select line is high and by M while it is low. Each division cycle lasts N2 input pulses. During the first N1 of them the select line is high, and during the rest it is low. Referred to the oscillator, the total ratio is therefore (M+1)·N1 + M·(N2−N1) = M·N2 + N1. At the end of each cycle the block emits a comparison pulse for the phase detector.

In AM mode the swallow part is idle. The select line stays low, and the input is divided directly by N2. The ratio and the mode are taken from the inputs only when a cycle ends, so a change never produces a malformed cycle. A ratio that cannot be built is refused, and the previous one stays in force. Reset is synchronous.

Top module: `swallow_divider`

## Requirements
- R1: During and after a synchronous reset with no input pulse counted yet, `cmp_pulse` is low. The ratio is loaded from the inputs if they are valid; otherwise the defaults N1=DEF_N1, N2=DEF_N2 in FM mode are used. `mod_sel` is high exactly when FM mode is active and N1>0.
- R2: `cmp_pulse` is high for exactly one input clock per division cycle. Successive rising edges of `cmp_pulse` lie N2 input clocks apart.
- R3: In FM mode (`fm_en`=1), `mod_sel` is high (prescaler divides by M+1) for the first N1 input clocks of a cycle and low (divide by M) for the remaining N2−N1. The oscillator ratio is M·N2+N1.
- R4: In AM mode (`fm_en`=0), `mod_sel` stays low for the whole cycle and the cycle lasts N2 input clocks. The value of `swallow_n` has no effect.
- R5: `swallow_n`, `prog_n` and `fm_en` are sampled only on the input clock that ends a cycle. A change during a cycle does not alter that cycle.
- R6: In FM mode a request with N1 ≥ N2 is refused, and the ratio and mode in force continue unchanged.
- R7: A request with N2 < 2 is refused in either mode, and the ratio and mode in force continue unchanged.
- R8: `mod_sel` rises only at the start of a cycle, on the same input clock in which `cmp_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output pulses (count clock) |
| rst | input | 1 | Synchronous reset, active high |
| fm_en | input | 1 | 1 = FM swallow operation, 0 = AM direct division |
| swallow_n | input | CW | Requested swallow count N1 |
| prog_n | input | CW | Requested programmable count N2 |
| mod_sel | output | 1 | Prescaler modulus select: 1 = M+1, 0 = M |
| cmp_pulse | output | 1 | Comparison pulse, one clock wide per cycle |

## Verification
A new ratio takes effect at the next cycle end. `cmp_pulse` rises one input clock after the N2-th pulse of a cycle. `mod_sel` follows the count in the same clock with no register delay. The bench therefore applies each request and waits for a `cmp_pulse` sample before it starts measuring. It then measures the whole following cycle, on falling edges, between two `cmp_pulse` samples. From that window it checks the length, the number of high `mod_sel` clocks and their position. For the mid-cycle case, the request is changed one clock after the pulse sample, and the bench expects the old ratio for the rest of that window.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int CW     = 8,
  parameter int DEF_N1 = 0,
  parameter int DEF_N2 = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fm_en,
  input  logic [CW-1:0] swallow_n,
  input  logic [CW-1:0] prog_n,
  output logic          mod_sel,
  output logic          cmp_pulse
);
  logic [CW-1:0] cnt, n1_q, n2_q;
  logic          fm_q, pulse_q;

  wire req_ok = (prog_n >= CW'(2)) && (!fm_en || (swallow_n < prog_n));
  wire wrap   = (cnt == n2_q - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pulse_q <= 1'b0;
      if (req_ok) begin
        n1_q <= swallow_n;
        n2_q <= prog_n;
        fm_q <= fm_en;
      end else begin
        n1_q <= CW'(DEF_N1);
        n2_q <= CW'(DEF_N2);
        fm_q <= 1'b1;
      end
    end else begin
      pulse_q <= wrap;
      if (wrap) begin
        cnt <= '0;
        if (req_ok) begin
          n1_q <= swallow_n;
          n2_q <= prog_n;
          fm_q <= fm_en;
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign mod_sel   = fm_q && (cnt < n1_q);
  assign cmp_pulse = pulse_q;
endmodule

module swallow_divider_chk #(parameter int CW = 8) (
  input logic          clk,
  input logic          rst,
  input logic          mod_sel,
  input logic          cmp_pulse,
  input logic          fm_q,
  input logic [CW-1:0] n1_q,
  input logic [CW-1:0] n2_q
);
  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst) cmp_pulse |=> !cmp_pulse); // R2
  AST_MOD_RISE_AT_START: assert property (@(posedge clk) disable iff (rst) $rose(mod_sel) |-> cmp_pulse); // R8
  AST_AM_MOD_LOW: assert property (@(posedge clk) disable iff (rst) !fm_q |-> !mod_sel); // R4
  AST_FM_ORDER: assert property (@(posedge clk) disable iff (rst) fm_q |-> (n1_q < n2_q)); // R6
  AST_N2_MIN: assert property (@(posedge clk) disable iff (rst) n2_q >= CW'(2)); // R7
  AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst) !$stable(n2_q) |-> cmp_pulse); // R5
endmodule

bind swallow_divider swallow_divider_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .mod_sel(mod_sel), .cmp_pulse(cmp_pulse),
  .fm_q(fm_q), .n1_q(n1_q), .n2_q(n2_q)
);

// File: tb/test_swallow_divider.sv
module test_swallow_divider;
  localparam int CLK_P = 10;
  localparam int CW    = 8;
  localparam int M     = 32;

  logic clk = 0, rst = 1, fm_en = 1;
  logic [CW-1:0] swallow_n = 3, prog_n = 10;
  logic mod_sel, cmp_pulse;
  int errors = 0, checks = 0;
  bit done = 0;

  swallow_divider #(.CW(CW)) i_swallow_divider (
    .clk(clk), .rst(rst), .fm_en(fm_en), .swallow_n(swallow_n),
    .prog_n(prog_n), .mod_sel(mod_sel), .cmp_pulse(cmp_pulse));

  always #(CLK_P/2) clk = ~clk;

  function automatic int exp_ratio(int n1, int n2, bit fm);
    return fm ? M*n2 + n1 : n2;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (cmp_pulse) return;
    end
  endtask

  // measure from a pulse sample to the next; optionally change request after first clock
  task automatic measure(output int len, output int highs, output bit contig,
                         input bit chg, input logic nf, input int nn1, input int nn2);
    bit seen_low = 0;
    len = 0; highs = 0; contig = 1;
    for (int i = 0; i < 600; i++) begin
      len++;
      if (mod_sel) begin highs++; if (seen_low) contig = 0; end
      else seen_low = 1;
      @(negedge clk);
      if (chg && i == 0) begin fm_en = nf; swallow_n = CW'(nn1); prog_n = CW'(nn2); end
      if (cmp_pulse) return;
    end
  endtask

  task automatic run(string req, logic f, int n1, int n2, int en1, int en2, bit ef);
    int len, highs, r; bit contig;
    fm_en = f; swallow_n = CW'(n1); prog_n = CW'(n2);
    wait_pulse();
    measure(len, highs, contig, 0, 0, 0, 0);
    chk({req, " length"}, len, en2);
    chk({req, " mod high count"}, highs, ef ? en1 : 0);
    chk({req, " mod contiguous"}, contig, 1);
    r = (M + 1) * highs + M * (len - highs);
    if (ef) chk({req, " total ratio"}, r, exp_ratio(en1, en2, 1));
  endtask

  initial begin
    int len, highs; bit contig;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pulse in reset", cmp_pulse, 0);
    chk("R1 mod in reset", mod_sel, 1);
    rst = 0;
    @(negedge clk);
    chk("R1 pulse after reset", cmp_pulse, 0);
    // R2 R3 basic FM
    run("R2 R3 fm 3/10", 1, 3, 10, 3, 10, 1);
    run("R3 fm n1=0", 1, 0, 7, 0, 7, 1);
    run("R3 fm n1=n2-1", 1, 8, 9, 8, 9, 1);
    // R4 AM, swallow value ignored even if above N2
    run("R4 am", 0, 50, 12, 0, 12, 0);
    run("R4 am n2=2", 0, 0, 2, 0, 2, 0);
    // R6 refused: keep AM 2
    run("R6 fm n1>=n2 refused", 1, 9, 9, 0, 2, 0);
    run("R3 fm restore", 1, 4, 11, 4, 11, 1);
    // R7 refused
    run("R7 n2<2 refused", 0, 0, 1, 4, 11, 1);
    run("R7 n2=0 refused", 1, 0, 0, 4, 11, 1);
    // R5 mid-cycle change does not affect running cycle
    wait_pulse();
    measure(len, highs, contig, 1, 1, 2, 5);
    chk("R5 old length kept", len, 11);
    chk("R5 old mod count kept", highs, 4);
    measure(len, highs, contig, 0, 0, 0, 0);
    chk("R5 new length", len, 5);
    chk("R5 new mod count", highs, 2);
    // random valid ratios
    for (int k = 0; k < 25; k++) begin
      int n2 = 2 + ($urandom % 40);
      int n1 = $urandom % n2;
      logic f = $urandom % 2;
      run(f ? "R3 random fm" : "R4 random am", f, n1, n2, n1, n2, f);
    end
    // R1 reset with invalid request uses defaults (N1=0, N2=10, FM)
    fm_en = 1; swallow_n = 5; prog_n = 3;
    @(negedge clk); rst = 1; @(negedge clk); @(negedge clk);
    chk("R1 default mod", mod_sel, 0);
    rst = 0;
    wait_pulse();
    measure(len, highs, contig, 0, 0, 0, 0);
    chk("R1 default length", len, 10);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule